// File: doc/BRIEF.md
# ECC Control and Status Register Block

This block is the machine-mode register slave that configures and reports error-correcting-code protection for five memory arrays: the instruction local memory, the data local memory, the instruction cache, the data cache and the TLB. Software reaches it through a plain register port (valid, write, 12-bit address, write data) with combinational read data. It drives per-array enable bits out to the arrays and trap logic, and an injection code with its select bit. It takes single-error and double-error pulses back from the arrays and gathers them into sticky status bits.

There are two enable bits for each array. One turns code checking on. The other allows a double error to raise an exception. Software writes each bit on its own.

The injection register holds a check code. It also holds a select bit that tells the arrays to store this code in place of the generated one. The same register carries the sticky status for both error kinds. A one-way lock freezes every register in the block until reset, so the configuration cannot be changed afterwards for security. Hardware still records errors while the block is locked.

Array index order is used on every per-array bus and status field: 0 instruction local memory, 1 data local memory, 2 instruction cache, 3 data cache, 4 TLB.

Top module: `ecc_csr_regs`

## Requirements
- R1: After reset, all enable bits, the injection code, the select bit, both status fields and the lock output are 0.
- R2: Address 0x7C0 (instruction local memory), 0x7C1 (data local memory) and 0x7DD (TLB) each hold two bits. Bit 0 is the array's code enable and bit 1 is its exception enable. Write-data bits above bit 1 are dropped and read back as 0.
- R3: Address 0x7CA holds the cache controls. Bit 0 is the instruction-cache code enable and bit 1 its exception enable. Bit 2 is the data-cache code enable and bit 3 its exception enable. Higher bits read back as 0.
- R4: Writing one enable bit of an array leaves that array's other enable bit as written. Each bit appears on `ecc_en[i]` or `exc_en[i]` from the cycle after the write.
- R5: Address 0x7C2 holds the injection code in bits [CODE_W-1:0] and the select in bit CODE_W (bit 8 by default). Both are written directly and drive `inj_code` and `inj_sel`.
- R6: A pulse on `err_double[i]` sets double-status bit i. That bit appears on `dbl_status[i]` and in 0x7C2 bit 16+i from the next cycle, and it stays set.
- R7: A pulse on `err_single[i]` sets single-status bit i. That bit appears on `sgl_status[i]` and in 0x7C2 bit 24+i from the next cycle, and it stays set.
- R8: A write to 0x7C2 clears each status bit whose write-data bit is 0 and keeps each one whose write-data bit is 1. A hardware error pulse in the same cycle as a clear leaves that bit set.
- R9: Writing 1 to bit 0 of 0x7DE sets the lock. Writing 0 there has no effect. The lock reads back as 1 in bit 0 and shows on `locked`.
- R10: While locked, writes to 0x7C0, 0x7C1, 0x7C2, 0x7CA, 0x7DD and 0x7DE change nothing. Error pulses still set status bits.
- R11: An access with `csr_valid` high to an address in 0x7C0 to 0x7DF that is not implemented returns 0 and raises `csr_illegal`. Implemented addresses, and addresses outside that range, leave `csr_illegal` low. Outside the range `csr_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | Register access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Unimplemented address in the block range |
| err_single | input | 5 | Single-error pulses, one per array |
| err_double | input | 5 | Double-error pulses, one per array |
| ecc_en | output | 5 | Code checking enable per array |
| exc_en | output | 5 | Double-error exception enable per array |
| inj_code | output | CODE_W | Injection check code |
| inj_sel | output | 1 | Use injection code on array writes |
| sgl_status | output | 5 | Sticky single-error status |
| dbl_status | output | 5 | Sticky double-error status |
| locked | output | 1 | Lock is set |

## Verification
The assertions assume that `csr_addr`, `csr_we` and `csr_wdata` are stable while `csr_valid` is high. They also assume that error pulses are synchronous to `clk` and carry no X once reset has been released. The bench changes every input only on the falling edge, so every value is settled across the rising edge that captures it. It holds each error input for exactly one cycle, which keeps the sticky-status checks tied to a single known edge. The bench also lines up one error pulse with a clearing write on purpose, to test the priority of hardware over software.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
   localparam int NUM_ARR = 5;

   typedef enum int {
      ARR_ILM = 0,
      ARR_DLM = 1,
      ARR_IC  = 2,
      ARR_DC  = 3,
      ARR_TLB = 4
   } arr_e;

   localparam logic [11:0] ADR_ILM   = 12'h7C0;
   localparam logic [11:0] ADR_DLM   = 12'h7C1;
   localparam logic [11:0] ADR_INJ   = 12'h7C2;
   localparam logic [11:0] ADR_CACHE = 12'h7CA;
   localparam logic [11:0] ADR_TLB   = 12'h7DD;
   localparam logic [11:0] ADR_LOCK  = 12'h7DE;
   localparam logic [11:0] RANGE_LO  = 12'h7C0;
   localparam logic [11:0] RANGE_HI  = 12'h7DF;

   typedef struct packed {
      logic ilm;
      logic dlm;
      logic inj;
      logic cache;
      logic tlb;
      logic lock;
      logic illegal;
   } dec_t;
endpackage

// File: rtl/ecc_csr_decode.sv
module ecc_csr_decode
   import ecc_csr_pkg::*;
(
   input  logic        valid,
   input  logic [11:0] addr,
   output dec_t        dec
);
   logic in_range;
   assign in_range = (addr >= RANGE_LO) && (addr <= RANGE_HI);

   always_comb begin
      dec = '0;
      if (valid && in_range) begin
         unique case (addr)
            ADR_ILM:   dec.ilm   = 1'b1;
            ADR_DLM:   dec.dlm   = 1'b1;
            ADR_INJ:   dec.inj   = 1'b1;
            ADR_CACHE: dec.cache = 1'b1;
            ADR_TLB:   dec.tlb   = 1'b1;
            ADR_LOCK:  dec.lock  = 1'b1;
            default:   dec.illegal = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ecc_csr_ctl.sv
module ecc_csr_ctl
   import ecc_csr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ok,
   input  dec_t               dec,
   input  logic [3:0]         wdata,
   output logic [NUM_ARR-1:0] ecc_en,
   output logic [NUM_ARR-1:0] exc_en
);
   for (genvar i = 0; i < NUM_ARR; i++) begin : g_arr
      logic       we;
      logic [1:0] d;
      if (i == int'(ARR_IC)) begin : g_ic
         assign we = wr_ok && dec.cache;
         assign d  = wdata[1:0];
      end else if (i == int'(ARR_DC)) begin : g_dc
         assign we = wr_ok && dec.cache;
         assign d  = wdata[3:2];
      end else if (i == int'(ARR_ILM)) begin : g_ilm
         assign we = wr_ok && dec.ilm;
         assign d  = wdata[1:0];
      end else if (i == int'(ARR_DLM)) begin : g_dlm
         assign we = wr_ok && dec.dlm;
         assign d  = wdata[1:0];
      end else begin : g_tlb
         assign we = wr_ok && dec.tlb;
         assign d  = wdata[1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ecc_en[i] <= 1'b0;
            exc_en[i] <= 1'b0;
         end else if (we) begin
            ecc_en[i] <= d[0];
            exc_en[i] <= d[1];
         end
      end
   end
endmodule

// File: rtl/ecc_csr_sticky.sv
module ecc_csr_sticky #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_set,
   input  logic         sw_we,
   input  logic [N-1:0] sw_keep,
   output logic [N-1:0] st
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st[i] <= 1'b0;
         else if (hw_set[i])
            st[i] <= 1'b1;
         else if (sw_we && !sw_keep[i])
            st[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc_csr_regs.sv
module ecc_csr_regs
   import ecc_csr_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CODE_W  = 8,
   parameter int DBL_LSB = 16,
   parameter int SGL_LSB = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_valid,
   input  logic               csr_we,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               csr_illegal,
   input  logic [NUM_ARR-1:0] err_single,
   input  logic [NUM_ARR-1:0] err_double,
   output logic [NUM_ARR-1:0] ecc_en,
   output logic [NUM_ARR-1:0] exc_en,
   output logic [CODE_W-1:0]  inj_code,
   output logic               inj_sel,
   output logic [NUM_ARR-1:0] sgl_status,
   output logic [NUM_ARR-1:0] dbl_status,
   output logic               locked
);
   localparam int SEL_BIT = CODE_W;

   if (SEL_BIT >= DBL_LSB) begin : g_bad_code
      $error("injection code overlaps double-error status field");
   end
   if (DBL_LSB + NUM_ARR > SGL_LSB) begin : g_bad_dbl
      $error("status fields overlap");
   end
   if (SGL_LSB + NUM_ARR > XLEN) begin : g_bad_xlen
      $error("status field exceeds register width");
   end

   dec_t dec;
   logic wr_ok;

   ecc_csr_decode u_dec (
      .valid (csr_valid),
      .addr  (csr_addr),
      .dec   (dec)
   );

   assign wr_ok = csr_valid && csr_we && !locked;

   ecc_csr_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .dec    (dec),
      .wdata  (csr_wdata[3:0]),
      .ecc_en (ecc_en),
      .exc_en (exc_en)
   );

   ecc_csr_sticky #(.N(NUM_ARR)) u_dbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (err_double),
      .sw_we   (wr_ok && dec.inj),
      .sw_keep (csr_wdata[DBL_LSB +: NUM_ARR]),
      .st      (dbl_status)
   );

   ecc_csr_sticky #(.N(NUM_ARR)) u_sgl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (err_single),
      .sw_we   (wr_ok && dec.inj),
      .sw_keep (csr_wdata[SGL_LSB +: NUM_ARR]),
      .st      (sgl_status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_code <= '0;
         inj_sel  <= 1'b0;
      end else if (wr_ok && dec.inj) begin
         inj_code <= csr_wdata[CODE_W-1:0];
         inj_sel  <= csr_wdata[SEL_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (wr_ok && dec.lock && csr_wdata[0])
         locked <= 1'b1;
   end

   always_comb begin
      csr_rdata = '0;
      if (dec.ilm) begin
         csr_rdata[1:0] = {exc_en[ARR_ILM], ecc_en[ARR_ILM]};
      end else if (dec.dlm) begin
         csr_rdata[1:0] = {exc_en[ARR_DLM], ecc_en[ARR_DLM]};
      end else if (dec.tlb) begin
         csr_rdata[1:0] = {exc_en[ARR_TLB], ecc_en[ARR_TLB]};
      end else if (dec.cache) begin
         csr_rdata[3:0] = {exc_en[ARR_DC], ecc_en[ARR_DC],
                           exc_en[ARR_IC], ecc_en[ARR_IC]};
      end else if (dec.inj) begin
         csr_rdata[CODE_W-1:0]          = inj_code;
         csr_rdata[SEL_BIT]             = inj_sel;
         csr_rdata[DBL_LSB +: NUM_ARR]  = dbl_status;
         csr_rdata[SGL_LSB +: NUM_ARR]  = sgl_status;
      end else if (dec.lock) begin
         csr_rdata[0] = locked;
      end
   end

   assign csr_illegal = dec.illegal;
endmodule

// File: rtl/ecc_csr_chk.sv
module ecc_csr_chk
   import ecc_csr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CODE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               csr_valid,
   input logic               csr_we,
   input logic [11:0]        csr_addr,
   input logic [XLEN-1:0]    csr_rdata,
   input logic               csr_illegal,
   input logic [NUM_ARR-1:0] err_single,
   input logic [NUM_ARR-1:0] err_double,
   input logic [NUM_ARR-1:0] ecc_en,
   input logic [NUM_ARR-1:0] exc_en,
   input logic [CODE_W-1:0]  inj_code,
   input logic               inj_sel,
   input logic [NUM_ARR-1:0] sgl_status,
   input logic [NUM_ARR-1:0] dbl_status,
   input logic               locked
);
   logic inj_wr;
   assign inj_wr = csr_valid && csr_we && (csr_addr == ADR_INJ);

   // R6
   dbl_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_double) |=> ((dbl_status & $past(err_double)) == $past(err_double)));

   // R7
   sgl_sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_single) |=> ((sgl_status & $past(err_single)) == $past(err_single)));

   // R8
   dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_wr |=> ((dbl_status & $past(dbl_status)) == $past(dbl_status)));

   // R8
   sgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_wr |=> ((sgl_status & $past(sgl_status)) == $past(sgl_status)));

   // R9
   lock_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R10
   frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(ecc_en) && $stable(exc_en) && $stable(inj_code) && $stable(inj_sel)));

   // R10
   frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(|err_double)) |=> (dbl_status == $past(dbl_status)));

   // R11
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0));

   // R11
   illegal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> csr_valid);
endmodule

bind ecc_csr_regs ecc_csr_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_valid   (csr_valid),
   .csr_we      (csr_we),
   .csr_addr    (csr_addr),
   .csr_rdata   (csr_rdata),
   .csr_illegal (csr_illegal),
   .err_single  (err_single),
   .err_double  (err_double),
   .ecc_en      (ecc_en),
   .exc_en      (exc_en),
   .inj_code    (inj_code),
   .inj_sel     (inj_sel),
   .sgl_status  (sgl_status),
   .dbl_status  (dbl_status),
   .locked      (locked)
);

// File: tb/ecc_csr_regs_tb.sv
`timescale 1ns/1ps
module ecc_csr_regs_tb;
   localparam int XLEN = 32;
   localparam int CODE_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              csr_valid = 1'b0;
   logic              csr_we = 1'b0;
   logic [11:0]       csr_addr = '0;
   logic [XLEN-1:0]   csr_wdata = '0;
   logic [XLEN-1:0]   csr_rdata;
   logic              csr_illegal;
   logic [4:0]        err_single = '0;
   logic [4:0]        err_double = '0;
   logic [4:0]        ecc_en, exc_en, sgl_status, dbl_status;
   logic [CODE_W-1:0] inj_code;
   logic              inj_sel;
   logic              locked;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   ecc_csr_regs #(.XLEN(XLEN), .CODE_W(CODE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .csr_illegal(csr_illegal), .err_single(err_single), .err_double(err_double),
      .ecc_en(ecc_en), .exc_en(exc_en), .inj_code(inj_code), .inj_sel(inj_sel),
      .sgl_status(sgl_status), .dbl_status(dbl_status), .locked(locked)
   );

   // {address, write data, expected read-back}
   localparam int NVEC = 10;
   localparam logic [75:0] VEC [NVEC] = '{
      {12'h7C0, 32'h0000_0003, 32'h0000_0003},  // R2 both bits
      {12'h7C0, 32'hFFFF_FFF1, 32'h0000_0001},  // R2 R4 upper dropped
      {12'h7C1, 32'h0000_0002, 32'h0000_0002},  // R2 R4 exc only
      {12'h7CA, 32'h0000_000F, 32'h0000_000F},  // R3
      {12'h7CA, 32'h0000_0005, 32'h0000_0005},  // R3 code enables
      {12'h7CA, 32'hFFFF_FFFA, 32'h0000_000A},  // R3 exc enables
      {12'h7DD, 32'h0000_0003, 32'h0000_0003},  // R2 tlb
      {12'h7C2, 32'h0000_01A5, 32'h0000_01A5},  // R5 code+sel
      {12'h7C2, 32'hFFFF_FFFF, 32'h0000_01FF},  // R5 R8 ones keep zero status
      {12'h7C2, 32'h0000_005A, 32'h0000_005A}   // R5 sel low
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_valid = 1'b0; csr_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic ill);
      @(negedge clk);
      csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a;
      #1;
      d = csr_rdata; ill = csr_illegal;
      @(negedge clk);
      csr_valid = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] s, input logic [4:0] dd);
      @(negedge clk);
      err_single = s; err_double = dd;
      @(negedge clk);
      err_single = '0; err_double = '0;
   endtask

   initial begin
      #1_000_000;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic        il;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {ecc_en, exc_en, sgl_status, dbl_status, inj_code, inj_sel, locked},
            32'h0);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rd(VEC[i][75:64], r, il);
         check("R2/R3/R5 vector", r, VEC[i][31:0]);
      end

      // R4 outputs after the table
      check("R4 ecc_en", {27'd0, ecc_en}, 32'h11);
      check("R4 exc_en", {27'd0, exc_en}, 32'h1E);
      check("R5 inj outputs", {23'd0, inj_sel, inj_code}, 32'h05A);

      // R6 double error on data cache
      pulse(5'b0, 5'b01000);
      check("R6 dbl_status", {27'd0, dbl_status}, 32'h08);
      rd(12'h7C2, r, il);
      check("R6 readback", r, 32'h0008_005A);
      repeat (3) @(negedge clk);
      check("R6 sticky", {27'd0, dbl_status}, 32'h08);

      // R7 single error on instruction local memory
      pulse(5'b00001, 5'b0);
      rd(12'h7C2, r, il);
      check("R7 readback", r, 32'h0108_005A);
      check("R7 sgl_status", {27'd0, sgl_status}, 32'h01);

      // R8 keep with ones
      wr(12'h7C2, 32'h0108_005A);
      rd(12'h7C2, r, il);
      check("R8 keep", r, 32'h0108_005A);

      // R8 clear with a same-cycle hardware set on dlm double
      @(negedge clk);
      csr_valid = 1'b1; csr_we = 1'b1; csr_addr = 12'h7C2; csr_wdata = 32'h0000_005A;
      err_double = 5'b00010;
      @(negedge clk);
      csr_valid = 1'b0; csr_we = 1'b0; err_double = '0;
      rd(12'h7C2, r, il);
      check("R8 clear, hw wins", r, 32'h0002_005A);

      // R11 decoding
      rd(12'h7C5, r, il);
      check("R11 hole data", r, 32'h0);
      check("R11 hole flag", {31'd0, il}, 32'h1);
      rd(12'h7DF, r, il);
      check("R11 top of range flag", {31'd0, il}, 32'h1);
      rd(12'h7C0, r, il);
      check("R11 implemented flag", {31'd0, il}, 32'h0);
      rd(12'h300, r, il);
      check("R11 outside flag", {31'd0, il}, 32'h0);
      check("R11 outside data", r, 32'h0);

      // R9 lock
      wr(12'h7DE, 32'h0000_0000);
      check("R9 zero no effect", {31'd0, locked}, 32'h0);
      wr(12'h7DE, 32'h0000_0001);
      check("R9 locked", {31'd0, locked}, 32'h1);
      rd(12'h7DE, r, il);
      check("R9 readback", r, 32'h1);

      // R10 writes ignored while locked
      wr(12'h7C0, 32'h0);
      wr(12'h7CA, 32'h0);
      wr(12'h7DD, 32'h0);
      wr(12'h7C2, 32'h0000_0100);
      wr(12'h7DE, 32'h0);
      check("R10 ecc_en frozen", {27'd0, ecc_en}, 32'h11);
      check("R10 exc_en frozen", {27'd0, exc_en}, 32'h1E);
      rd(12'h7C2, r, il);
      check("R10 inj frozen", r, 32'h0002_005A);
      check("R10 lock kept", {31'd0, locked}, 32'h1);
      pulse(5'b10000, 5'b0);
      rd(12'h7C2, r, il);
      check("R10 hw set while locked", r, 32'h1002_005A);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule